// File: doc/BRIEF.md
# PCI Target Transaction Controller

This block sits between a conventional PCI bus and simple on-chip user logic. It watches the multiplexed address/data lines and the framing handshakes on every rising clock edge. It records the address and bus command at the start of a transaction and decides whether the command belongs to it. When it accepts a transaction, it acknowledges it and paces every data phase on the bus side. On the user side it presents plain, non-multiplexed strobes.

The user logic sees a separate address bus, a write data bus with byte enables, a read data input and one-cycle read and write strobes, as on a classic expansion-bus peripheral. Memory transactions may burst, and the address advances by one word per transfer. I/O and configuration transactions carry one word only; an attempt to burst them is cut off with a disconnect. The block never initiates transfers.

Top module: `pci_target_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `devsel_n`, `trdy_n` and `stop_n` are 1, `ctl_oe` and `ad_oe` are 0, and `u_rd` and `u_wr` are 0.
- R2: Only the codes on `cbe_n` sampled at the start edge claim a transaction: 0010 and 0011 (I/O read and write), 0110 and 0111 (memory read and write), and 1010 and 1011 (configuration read and write), where the configuration codes count only with `idsel` high. Any other code, or a configuration code with `idsel` low, leaves `devsel_n` high and produces no strobe.
- R3: For a claimed transaction whose start edge is A, `devsel_n` goes low and `ctl_oe` goes high after edge A+1. `devsel_n` stays low until the termination clock of R9.
- R4: `trdy_n` first goes low after edge A+2. A word moves only on an edge where both `irdy_n` and `trdy_n` are low. While `irdy_n` is high, the target holds its state.
- R5: For a read (code bit 0 equal to 0), `u_rd` pulses for one cycle after edge A+1 with `u_addr` holding the start address. After edge A+2, `ad_o` carries the `u_rdata` value sampled at that edge and `ad_oe` is 1. `ad_oe` is 0 before that point.
- R6: For a write, each transfer edge causes a one-cycle `u_wr` pulse in the next cycle. During that pulse `u_addr` holds the word address, `u_wdata` holds the AD value of that edge, and `u_be` holds the bitwise inverse of `cbe_n` from that edge.
- R7: In memory bursts the word address rises by 4 after every transfer. A memory read takes one cycle with `trdy_n` high between words, during which `u_rd` pulses with the next address.
- R8: For I/O and configuration accesses, if `frame_n` is still low at edge A+2, `stop_n` goes low together with `trdy_n`. After that transfer, `stop_n` and `devsel_n` stay low, and `trdy_n` stays high, until `frame_n` is sampled high.
- R9: After a transfer with `frame_n` high, or after the end of a disconnect, the target drives `devsel_n`, `trdy_n` and `stop_n` high with `ctl_oe` at 1 and `ad_oe` at 0 for one clock. It then drops `ctl_oe` to 0.
- R10: A new start edge is recognised only in the idle state, and only when `frame_n` is low and was high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Transaction framing from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this device |
| cbe_n | input | 4 | Command in the start phase, active-low byte enables in data phases |
| ad_i | input | 32 | Address/data lines as seen by the target |
| ad_o | output | 32 | Read data to drive onto the address/data lines |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| devsel_n | output | 1 | Claim acknowledge, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| ctl_oe | output | 1 | Drive enable for `devsel_n`, `trdy_n` and `stop_n` |
| u_rst | output | 1 | Reset forwarded to user logic |
| u_space | output | 2 | Space of the current access: 01 I/O, 10 memory, 11 configuration |
| u_addr | output | 32 | Demultiplexed user address |
| u_wdata | output | 32 | User write data |
| u_be | output | 4 | User byte enables, active high |
| u_rdata | input | 32 | User read data, sampled one cycle after `u_rd` |
| u_rd | output | 1 | One-cycle read strobe |
| u_wr | output | 1 | One-cycle write strobe |

## Verification
The bound checker enforces the handshake relations on every cycle. `trdy_n` can fall only after `devsel_n` was low. The target signals are always driven while `devsel_n` or `stop_n` is low, and read data is driven only inside a claim. The release clock has all three target signals high and is followed by the drive being dropped. Every write strobe traces back to an edge where both ready signals were low. The bench scenarios cover the parts that depend on the command code and its cycle counts: which codes are claimed, the exact edges at which claim, ready and read data appear, address stepping in bursts, and the disconnect on multi-word I/O requests. Values passed between bus and user side are checked against an independent cycle model.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_FETCH,
        ST_DATA,
        ST_TERM,
        ST_TURN
    } tgt_state_e;

    typedef enum logic [1:0] {
        SP_NONE = 2'b00,
        SP_IO   = 2'b01,
        SP_MEM  = 2'b10,
        SP_CFG  = 2'b11
    } space_e;

    typedef struct packed {
        logic   rd;
        logic   single;
        space_e sp;
    } txn_t;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    function automatic space_e space_of(input logic [3:0] cmd, input logic sel);
        space_e sp;
        unique case (cmd)
            CMD_IO_RD, CMD_IO_WR:   sp = SP_IO;
            CMD_MEM_RD, CMD_MEM_WR: sp = SP_MEM;
            CMD_CFG_RD, CMD_CFG_WR: sp = sel ? SP_CFG : SP_NONE;
            default:                sp = SP_NONE;
        endcase
        return sp;
    endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
(
    input  logic [3:0] cmd,
    input  logic       idsel,
    output logic       claim,
    output txn_t       txn
);
    space_e sp;

    always_comb begin
        sp         = space_of(cmd, idsel);
        claim      = (sp != SP_NONE);
        txn.sp     = sp;
        txn.rd     = ~cmd[0];
        txn.single = (sp != SP_MEM);
    end
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
    import pci_tgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_n,
    input  logic   irdy_n,
    input  logic   claim,
    input  txn_t   txn_in,
    output logic   devsel_n,
    output logic   trdy_n,
    output logic   stop_n,
    output logic   ctl_oe,
    output space_e space,
    output logic   ev_addr,
    output logic   ev_adv,
    output logic   ev_rdreq,
    output logic   ev_rdcap,
    output logic   ev_wr,
    output logic   ev_end
);
    tgt_state_e st;
    txn_t       txn_q;
    logic       frame_prev;
    logic       xfer;

    always_comb begin
        xfer     = (st == ST_DATA) && !irdy_n;
        ev_addr  = (st == ST_IDLE) && !frame_n && frame_prev && claim;
        ev_adv   = xfer;
        ev_wr    = xfer && !txn_q.rd;
        ev_rdreq = ((st == ST_DECODE) && txn_q.rd)
                 || (xfer && txn_q.rd && !frame_n && stop_n);
        ev_rdcap = (st == ST_FETCH) && txn_q.rd;
        ev_end   = xfer && (frame_n || !stop_n);
        space    = txn_q.sp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            devsel_n   <= 1'b1;
            trdy_n     <= 1'b1;
            stop_n     <= 1'b1;
            ctl_oe     <= 1'b0;
            frame_prev <= 1'b1;
            txn_q      <= '{rd: 1'b0, single: 1'b0, sp: SP_NONE};
        end else begin
            frame_prev <= frame_n;
            unique case (st)
                ST_IDLE: begin
                    if (ev_addr) begin
                        txn_q <= txn_in;
                        st    <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    devsel_n <= 1'b0;
                    ctl_oe   <= 1'b1;
                    st       <= ST_FETCH;
                end
                ST_FETCH: begin
                    trdy_n <= 1'b0;
                    stop_n <= !(txn_q.single && !frame_n);
                    st     <= ST_DATA;
                end
                ST_DATA: begin
                    if (xfer) begin
                        if (frame_n) begin
                            devsel_n <= 1'b1;
                            trdy_n   <= 1'b1;
                            stop_n   <= 1'b1;
                            st       <= ST_TURN;
                        end else if (!stop_n) begin
                            trdy_n <= 1'b1;
                            st     <= ST_TERM;
                        end else if (txn_q.rd) begin
                            trdy_n <= 1'b1;
                            st     <= ST_FETCH;
                        end
                    end
                end
                ST_TERM: begin
                    if (frame_n) begin
                        devsel_n <= 1'b1;
                        stop_n   <= 1'b1;
                        st       <= ST_TURN;
                    end
                end
                ST_TURN: begin
                    ctl_oe <= 1'b0;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pci_tgt_dpath.sv
module pci_tgt_dpath #(
    parameter int AD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AD_W-1:0]   ad_i,
    input  logic [AD_W/8-1:0] cbe_n,
    input  logic [AD_W-1:0]   u_rdata,
    input  logic              ev_addr,
    input  logic              ev_adv,
    input  logic              ev_rdreq,
    input  logic              ev_rdcap,
    input  logic              ev_wr,
    input  logic              ev_end,
    output logic [AD_W-1:0]   ad_o,
    output logic              ad_oe,
    output logic [AD_W-1:0]   u_addr,
    output logic [AD_W-1:0]   u_wdata,
    output logic [AD_W/8-1:0] u_be,
    output logic              u_rd,
    output logic              u_wr
);
    localparam int BE_W = AD_W / 8;
    localparam logic [AD_W-1:0] STRIDE = AD_W'(BE_W);

    logic [AD_W-1:0] cur;
    logic [AD_W-1:0] nxt;

    assign nxt = cur + STRIDE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            u_addr  <= '0;
            u_wdata <= '0;
            u_be    <= '0;
            u_rd    <= 1'b0;
            u_wr    <= 1'b0;
            ad_o    <= '0;
            ad_oe   <= 1'b0;
        end else begin
            u_rd <= ev_rdreq;
            u_wr <= ev_wr;
            if (ev_addr)
                cur <= ad_i;
            else if (ev_adv)
                cur <= nxt;
            if (ev_rdreq)
                u_addr <= ev_adv ? nxt : cur;
            else if (ev_wr)
                u_addr <= cur;
            if (ev_wr) begin
                u_wdata <= ad_i;
                u_be    <= ~cbe_n;
            end
            if (ev_rdcap) begin
                ad_o  <= u_rdata;
                ad_oe <= 1'b1;
            end else if (ev_end) begin
                ad_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pci_target_ctrl.sv
module pci_target_ctrl
    import pci_tgt_pkg::*;
#(
    parameter int AD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic [AD_W/8-1:0] cbe_n,
    input  logic [AD_W-1:0]   ad_i,
    output logic [AD_W-1:0]   ad_o,
    output logic              ad_oe,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              ctl_oe,
    output logic              u_rst,
    output logic [1:0]        u_space,
    output logic [AD_W-1:0]   u_addr,
    output logic [AD_W-1:0]   u_wdata,
    output logic [AD_W/8-1:0] u_be,
    input  logic [AD_W-1:0]   u_rdata,
    output logic              u_rd,
    output logic              u_wr
);
    logic   claim;
    txn_t   txn_dec;
    space_e space;
    logic   ev_addr, ev_adv, ev_rdreq, ev_rdcap, ev_wr, ev_end;

    assign u_rst   = rst;
    assign u_space = space;

    pci_tgt_decode u_dec (
        .cmd   (cbe_n[3:0]),
        .idsel (idsel),
        .claim (claim),
        .txn   (txn_dec)
    );

    pci_tgt_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .claim    (claim),
        .txn_in   (txn_dec),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .stop_n   (stop_n),
        .ctl_oe   (ctl_oe),
        .space    (space),
        .ev_addr  (ev_addr),
        .ev_adv   (ev_adv),
        .ev_rdreq (ev_rdreq),
        .ev_rdcap (ev_rdcap),
        .ev_wr    (ev_wr),
        .ev_end   (ev_end)
    );

    pci_tgt_dpath #(.AD_W(AD_W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ad_i     (ad_i),
        .cbe_n    (cbe_n),
        .u_rdata  (u_rdata),
        .ev_addr  (ev_addr),
        .ev_adv   (ev_adv),
        .ev_rdreq (ev_rdreq),
        .ev_rdcap (ev_rdcap),
        .ev_wr    (ev_wr),
        .ev_end   (ev_end),
        .ad_o     (ad_o),
        .ad_oe    (ad_oe),
        .u_addr   (u_addr),
        .u_wdata  (u_wdata),
        .u_be     (u_be),
        .u_rd     (u_rd),
        .u_wr     (u_wr)
    );
endmodule

// File: rtl/pci_tgt_checker.sv
module pci_tgt_checker (
    input logic clk,
    input logic rst,
    input logic irdy_n,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic ctl_oe,
    input logic ad_oe,
    input logic u_rd,
    input logic u_wr
);
    // R4: ready may only fall once the claim was already visible
    a_r4_trdy_after_devsel: assert property (@(posedge clk) disable iff (rst)
        $fell(trdy_n) |-> $past(!devsel_n));

    // R3: a claim is always actively driven
    a_r3_devsel_driven: assert property (@(posedge clk) disable iff (rst)
        !devsel_n |-> ctl_oe);

    // R5: read data is driven only inside a claim
    a_r5_ad_in_claim: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !devsel_n);

    // R8: stop is only raised while the transaction is claimed
    a_r8_stop_in_claim: assert property (@(posedge clk) disable iff (rst)
        !stop_n |-> !devsel_n);

    // R9: release clock drives all target signals high
    a_r9_turn_high: assert property (@(posedge clk) disable iff (rst)
        $rose(devsel_n) |-> (trdy_n && stop_n && ctl_oe));

    // R9: drive is dropped one clock after release
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        $rose(devsel_n) |=> !ctl_oe);

    // R6: each write strobe follows a both-ready edge
    a_r6_wr_after_xfer: assert property (@(posedge clk) disable iff (rst)
        u_wr |-> $past(!trdy_n && !irdy_n));

    // R5: read and write strobes never coincide
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(u_rd && u_wr));
endmodule

bind pci_target_ctrl pci_tgt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .irdy_n   (irdy_n),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .ctl_oe   (ctl_oe),
    .ad_oe    (ad_oe),
    .u_rd     (u_rd),
    .u_wr     (u_wr)
);

// File: tb/tb_pci_target_ctrl.sv
module tb_pci_target_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [3:0]  cbe_n = 4'h0;
    logic [31:0] ad_i = '0;
    logic [31:0] ad_o, u_addr, u_wdata, u_rdata;
    logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe, u_rst, u_rd, u_wr;
    logic [1:0]  u_space;
    logic [3:0]  u_be;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    assign u_rdata = u_addr ^ 32'hA5A5_0000;

    pci_target_ctrl dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .cbe_n(cbe_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
        .u_rst(u_rst), .u_space(u_space), .u_addr(u_addr), .u_wdata(u_wdata),
        .u_be(u_be), .u_rdata(u_rdata), .u_rd(u_rd), .u_wr(u_wr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_ph = 0;         // 0 idle 1 claim-next 2 ready-next 3 data 4 hold-stop 5 release
    bit          m_fprev = 1, m_rd = 0, m_one = 0;
    logic [31:0] m_cur = 0;
    logic        e_dev = 1, e_trdy = 1, e_stop = 1, e_oe = 0, e_adoe = 0, e_urd = 0, e_uwr = 0;
    logic [31:0] e_ado = 0, e_uaddr = 0, e_wdata = 0;
    logic [3:0]  e_be = 0;

    function automatic bit takes(input logic [3:0] c, input logic sel);
        case (c)
            4'd2, 4'd3, 4'd6, 4'd7: return 1;
            4'd10, 4'd11:           return sel;
            default:                return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ph = 0; m_fprev = 1;
            e_dev = 1; e_trdy = 1; e_stop = 1; e_oe = 0; e_adoe = 0; e_urd = 0; e_uwr = 0;
        end else begin
            bit was_stop;
            was_stop = !e_stop;
            e_urd = 0; e_uwr = 0;
            case (m_ph)
                0: if (!frame_n && m_fprev && takes(cbe_n, idsel)) begin
                       m_cur = ad_i; m_rd = !cbe_n[0];
                       m_one = (cbe_n != 4'd6 && cbe_n != 4'd7); m_ph = 1;
                   end
                1: begin
                       e_dev = 0; e_oe = 1;
                       if (m_rd) begin e_urd = 1; e_uaddr = m_cur; end
                       m_ph = 2;
                   end
                2: begin
                       e_trdy = 0; e_stop = !(m_one && !frame_n);
                       if (m_rd) begin e_ado = u_rdata; e_adoe = 1; end
                       m_ph = 3;
                   end
                3: if (!irdy_n) begin
                       if (!m_rd) begin
                           e_uwr = 1; e_uaddr = m_cur; e_wdata = ad_i; e_be = ~cbe_n;
                       end
                       m_cur = m_cur + 4;
                       if (frame_n) begin
                           e_dev = 1; e_trdy = 1; e_stop = 1; e_adoe = 0; m_ph = 5;
                       end else if (was_stop) begin
                           e_trdy = 1; e_adoe = 0; m_ph = 4;
                       end else if (m_rd) begin
                           e_trdy = 1; e_urd = 1; e_uaddr = m_cur; m_ph = 2;
                       end
                   end
                4: if (frame_n) begin e_dev = 1; e_stop = 1; m_ph = 5; end
                5: begin e_oe = 0; m_ph = 0; end
                default: m_ph = 0;
            endcase
            m_fprev = frame_n;
        end
        if (cyc > 20000) begin
            chk(0, "watchdog", cyc, 20000);
            finish_run();
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !rst) begin
            chk(devsel_n === e_dev,  "R3 devsel_n", devsel_n, e_dev);
            chk(trdy_n   === e_trdy, "R4 trdy_n",   trdy_n,   e_trdy);
            chk(stop_n   === e_stop, "R8 stop_n",   stop_n,   e_stop);
            chk(ctl_oe   === e_oe,   "R9 ctl_oe",   ctl_oe,   e_oe);
            chk(ad_oe    === e_adoe, "R5 ad_oe",    ad_oe,    e_adoe);
            if (e_adoe) chk(ad_o === e_ado, "R5 ad_o", ad_o, e_ado);
            chk(u_rd === e_urd, "R5 u_rd", u_rd, e_urd);
            chk(u_wr === e_uwr, "R6 u_wr", u_wr, e_uwr);
            if (e_urd || e_uwr) chk(u_addr === e_uaddr, "R7 u_addr", u_addr, e_uaddr);
            if (e_uwr) begin
                chk(u_wdata === e_wdata, "R6 u_wdata", u_wdata, e_wdata);
                chk(u_be === e_be, "R6 u_be", u_be, e_be);
            end
        end
    end

    // write log
    logic [31:0] q_addr[$], q_data[$];
    logic [3:0]  q_be[$];
    always @(negedge clk) begin
        if (!rst && u_wr) begin
            q_addr.push_back(u_addr); q_data.push_back(u_wdata); q_be.push_back(u_be);
        end
    end

    function automatic logic [31:0] wpat(input int i);
        return 32'hC0DE_0000 | 32'(i);
    endfunction

    // initiator: nw words requested, iw idle cycles before first ready
    task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                        input int nw, input int iw, output int got);
        int  i = 0, waits = iw, guard = 0;
        bit  done = 0, stopped = 0;
        logic t, s;
        logic [31:0] d;
        got = 0;
        @(negedge clk);
        frame_n = 0; irdy_n = 1; ad_i = addr; cbe_n = cmd; idsel = sel;
        while (!done && guard < 60) begin
            @(negedge clk);
            guard++;
            idsel = 0;
            if (stopped) begin
                frame_n = 1; irdy_n = 0;
            end else if (waits > 0) begin
                irdy_n = 1; waits--;
            end else begin
                irdy_n = 0;
                frame_n = (i == nw - 1);
                cbe_n = 4'(i);
                ad_i = cmd[0] ? wpat(i) : 32'h0;
            end
            t = trdy_n; s = stop_n; d = ad_o;
            @(posedge clk);
            #1;
            if (stopped) done = 1;
            else if (!irdy_n && !t) begin
                if (!cmd[0])
                    chk(d === ((addr + 32'(4*i)) ^ 32'hA5A5_0000), "R5 read word", d,
                        (addr + 32'(4*i)) ^ 32'hA5A5_0000);
                i++; got++;
                if (frame_n) done = 1;
                else if (!s) stopped = 1;
            end
        end
        if (!done) chk(0, "R4 initiator timeout", 32'(guard), 0);
        @(negedge clk);
        frame_n = 1; irdy_n = 1;
        repeat (2) @(negedge clk);
    endtask

    // start edge that must not be claimed; cmd2 replaces the code while FRAME stays low
    task automatic probe(input logic [3:0] cmd, input logic [3:0] cmd2, input logic sel,
                         input string tag);
        int lows = 0;
        @(negedge clk);
        frame_n = 0; irdy_n = 1; ad_i = 32'h40; cbe_n = cmd; idsel = sel;
        @(negedge clk);
        cbe_n = cmd2; irdy_n = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!devsel_n || u_rd || u_wr) lows++;
        end
        frame_n = 1; irdy_n = 1; idsel = 0;
        repeat (3) @(negedge clk);
        chk(lows == 0, tag, 32'(lows), 0);
    endtask

    initial begin
        int got;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(devsel_n && trdy_n && stop_n, "R1 ctl high in reset", {devsel_n, trdy_n, stop_n}, 3'b111);
        chk(!ctl_oe && !ad_oe, "R1 drives off in reset", {ctl_oe, ad_oe}, 0);
        chk(!u_rd && !u_wr && u_rst, "R1 strobes in reset", {u_rd, u_wr, u_rst}, 3'b001);
        rst = 0;
        started = 1;
        @(negedge clk);
        chk(devsel_n && trdy_n && stop_n && !ctl_oe, "R1 after reset",
            {devsel_n, trdy_n, stop_n, ctl_oe}, 4'b1110);

        // R6 R7 memory write burst
        q_addr.delete(); q_data.delete(); q_be.delete();
        xact(4'b0111, 32'h0000_1000, 0, 4, 0, got);
        chk(got == 4, "R7 mem write burst length", 32'(got), 4);
        chk(q_addr.size() == 4, "R6 write strobes", 32'(q_addr.size()), 4);
        for (int k = 0; k < 4 && k < q_addr.size(); k++) begin
            chk(q_addr[k] == 32'h1000 + 32'(4*k), "R7 burst address", q_addr[k], 32'h1000 + 32'(4*k));
            chk(q_data[k] == wpat(k), "R6 write data", q_data[k], wpat(k));
            chk(q_be[k] == ~4'(k), "R6 byte enables", q_be[k], ~4'(k));
        end

        // R5 R7 memory read burst with initiator waits (R4)
        xact(4'b0110, 32'h0000_2000, 0, 3, 2, got);
        chk(got == 3, "R7 mem read burst length", 32'(got), 3);

        // R5 single I/O read
        xact(4'b0010, 32'h0000_0300, 0, 1, 0, got);
        chk(got == 1, "R5 io read", 32'(got), 1);

        // R8 I/O write asked as burst is disconnected
        q_addr.delete(); q_data.delete(); q_be.delete();
        xact(4'b0011, 32'h0000_0310, 0, 2, 0, got);
        chk(got == 1, "R8 io disconnect", 32'(got), 1);
        chk(q_addr.size() == 1, "R8 one io write", 32'(q_addr.size()), 1);

        // R8 configuration read burst request with idsel
        xact(4'b1010, 32'h0000_0008, 1, 3, 0, got);
        chk(got == 1, "R8 cfg read disconnect", 32'(got), 1);

        // R4 memory write single after initiator waits
        xact(4'b0111, 32'h0000_3000, 0, 1, 3, got);
        chk(got == 1, "R4 delayed write", 32'(got), 1);

        // R2 unsupported or unselected codes
        probe(4'b1011, 4'b1011, 0, "R2 cfg write without idsel");
        probe(4'b0001, 4'b0001, 1, "R2 special code ignored");
        probe(4'b1100, 4'b1100, 0, "R2 other memory code ignored");
        // R10 code change while FRAME stays low is not a new start
        probe(4'b0000, 4'b0111, 0, "R10 no start without FRAME high");

        // R2 R10 a claimed access still works afterwards
        xact(4'b0110, 32'h0000_4000, 0, 1, 0, got);
        chk(got == 1, "R10 claim after probes", 32'(got), 1);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule